// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host read and write the on-chip program and data RAM without stopping the processor. The host uses one 16-bit bus for both addresses and data. First it pulses an address-latch strobe to load a start address and a memory-type bit. After that, every select-plus-read or select-plus-write pulse moves one bus word and steps the address forward, so a block transfer needs its start address only once.

All host strobes are asynchronous. They pass through a two-flop synchronizer, and edge detection then runs on the processor clock. Each access spends one cycle leaving the idle state and one cycle on the RAM itself. The acknowledge line drops for that access cycle and rises again once read data are on the bus.

Data words are 16 bits wide. Program words are 24 bits wide and take two bus transfers: the upper 16 bits go first, then the low byte. Host writes into the 32 highest data addresses are discarded, because that range holds the processor's control registers. A boot-hold output keeps the processor waiting until the host has written program location 0.

Top module: `hmap_top`

## Requirements
- R1: After synchronous reset, `host_ack` is 1 and `host_ad_oe` is 0. `boot_hold` equals the value of `boot_mode` sampled during reset.
- R2: A falling edge of `host_ale` loads the start address from `host_ad_in[13:0]` and the memory type from `host_ad_in[14]` (1 selects data memory, 0 selects program memory). The falling edge also returns the program-word transfer to its upper-half beat.
- R3: An access starts when `host_sel` is 1 together with `host_rd` or `host_wr`, with all three strobes active high. Take edge 1 as the first rising clock edge after the strobe is asserted. `host_ack` is 0 after edge 3 and 1 again after edge 4. For a read, `host_ad_out` holds the data and `host_ad_oe` is 1 after edge 4. `host_ad_oe` returns to 0 once the strobe is released.
- R4: Data memory moves one 16-bit word per transfer, and the address increments after each access, wrapping from 0x3FFF to 0x0000. The storage holds 2^DM_AW words, indexed by the low DM_AW address bits.
- R5: Writes to data addresses 0x3FE0 through 0x3FFF store nothing. The handshake still completes and the address still increments.
- R6: A program word takes two transfers. The first carries bits 23:8. The second carries bits 7:0 on `host_ad_in[7:0]`/`host_ad_out[7:0]`, and on a read the upper byte of the bus is 0. The address increments only after the second transfer, and the RAM is written only on the second transfer. Storage is indexed by the low PM_AW address bits.
- R7: `boot_hold` goes to 0 in the cycle in which the second transfer of a program-memory write to address 0 completes. After the first transfer it is still 1.
- R8: A strobe that stays asserted performs exactly one access. The next access needs the strobe to be released and asserted again.
- R9: `host_rd` or `host_wr` asserted while `host_sel` is 0 starts no access. `host_ack` stays 1 and the address is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Host-boot configuration, sampled during reset |
| host_sel | input | 1 | Host select, active high, asynchronous |
| host_rd | input | 1 | Host read strobe, active high, asynchronous |
| host_wr | input | 1 | Host write strobe, active high, asynchronous |
| host_ale | input | 1 | Address-latch strobe; its falling edge loads the address |
| host_ad_in | input | 16 | Address or write data from the host |
| host_ad_out | output | 16 | Read data to the host |
| host_ad_oe | output | 1 | Bus drive enable for read data |
| host_ack | output | 1 | Ready acknowledge; 0 while an access is in progress |
| boot_hold | output | 1 | Holds the processor in boot until program address 0 is written |

## Verification
The bench targets the protected window. It writes a data word through an alias address, then writes to the protected alias of the same storage word. A design that ignored the window would show the second value on read-back. The bench also tries a design that skipped the address step after a protected write, which would shift every following word. A wrong beat order in program transfers would swap the halves of the word or zero them, and an address that stepped after the first beat would interleave neighbouring words. The bench holds a strobe for many cycles to catch level-triggered accesses. It pulses read with select low, which would otherwise consume an address. It also checks that boot hold survives the first beat of the write to location 0 and clears on the second.

// File: rtl/hmap_pkg.sv
package hmap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_DONE   = 2'd2
  } hmap_state_t;
endpackage

// File: rtl/hmap_sync.sv
module hmap_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= '0;
        else     chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hmap_ram.sv
module hmap_ram #(
  parameter int W  = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  q
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/hmap_ctrl.sv
module hmap_ctrl
  import hmap_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int ADDR_W    = 14,
  parameter int LO_W      = 8,
  parameter int PROT_WORDS = 32,
  parameter int PM_AW     = 10,
  parameter int DM_AW     = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  boot_mode,
  input  logic                  ale_s,
  input  logic                  sel_s,
  input  logic                  rd_s,
  input  logic                  wr_s,
  input  logic [BUS_W-1:0]      ad_in,
  output logic                  ack,
  output logic                  oe,
  output logic                  boot_hold,
  output logic                  pm_we,
  output logic                  pm_re,
  output logic [PM_AW-1:0]      pm_addr,
  output logic [BUS_W+LO_W-1:0] pm_wdata,
  output logic                  dm_we,
  output logic                  dm_re,
  output logic [DM_AW-1:0]      dm_addr,
  output logic [BUS_W-1:0]      dm_wdata,
  output logic                  rd_dm,
  output logic                  rd_lo
);
  localparam logic [ADDR_W-1:0] PROT_BASE = ADDR_W'((1 << ADDR_W) - PROT_WORDS);

  hmap_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic [BUS_W-1:0]  hi_q;
  logic is_dm_q, beat_q, op_wr_q, ack_q, oe_q, boot_q, rd_dm_q, rd_lo_q;
  logic ale_d, stb_d;

  wire stb      = sel_s & (rd_s | wr_s);
  wire ale_fall = ale_d & ~ale_s;
  wire stb_rise = stb & ~stb_d;
  wire acc      = (state == ST_ACCESS);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_d <= 1'b0;
      stb_d <= 1'b0;
    end else begin
      ale_d <= ale_s;
      stb_d <= stb;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      hi_q    <= '0;
      is_dm_q <= 1'b0;
      beat_q  <= 1'b0;
      op_wr_q <= 1'b0;
      ack_q   <= 1'b1;
      oe_q    <= 1'b0;
      boot_q  <= boot_mode;
      rd_dm_q <= 1'b0;
      rd_lo_q <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ale_fall) begin
            addr_q  <= ad_in[ADDR_W-1:0];
            is_dm_q <= ad_in[ADDR_W];
            beat_q  <= 1'b0;
          end else if (stb_rise) begin
            state   <= ST_ACCESS;
            ack_q   <= 1'b0;
            op_wr_q <= wr_s;
          end
        end
        ST_ACCESS: begin
          state   <= ST_DONE;
          ack_q   <= 1'b1;
          oe_q    <= ~op_wr_q;
          rd_dm_q <= is_dm_q;
          rd_lo_q <= beat_q;
          if (is_dm_q || beat_q) addr_q <= addr_q + 1'b1;
          if (!is_dm_q) beat_q <= ~beat_q;
          if (!is_dm_q && !beat_q && op_wr_q) hi_q <= ad_in;
          if (op_wr_q && !is_dm_q && beat_q && addr_q == '0) boot_q <= 1'b0;
        end
        ST_DONE: begin
          if (!stb) begin
            state <= ST_IDLE;
            oe_q  <= 1'b0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pm_we    = acc & op_wr_q & ~is_dm_q & beat_q;
  assign pm_re    = acc & ~op_wr_q & ~is_dm_q;
  assign dm_we    = acc & op_wr_q & is_dm_q & (addr_q < PROT_BASE);
  assign dm_re    = acc & ~op_wr_q & is_dm_q;
  assign pm_addr  = addr_q[PM_AW-1:0];
  assign dm_addr  = addr_q[DM_AW-1:0];
  assign pm_wdata = {hi_q, ad_in[LO_W-1:0]};
  assign dm_wdata = ad_in;
  assign ack       = ack_q;
  assign oe        = oe_q;
  assign boot_hold = boot_q;
  assign rd_dm     = rd_dm_q;
  assign rd_lo     = rd_lo_q;

  // R4: a data access steps the address by one, wrapping at the top
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
    (acc && is_dm_q) |=> (addr_q == $past(addr_q) + 1'b1));

  // R6: the first program beat keeps the address and arms the second beat
  assert_beat_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && !is_dm_q && !beat_q) |=> (beat_q && addr_q == $past(addr_q)));

  // R3: acknowledge only returns after the RAM access cycle
  assert_ack_return_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> $past(acc));

  // R7: boot hold only drops on the second-beat write to program address 0
  assert_boot_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(boot_q) |-> $past(pm_we && addr_q == '0));

  // R8: a finished access never restarts without going idle
  assert_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |=> (state != ST_ACCESS));
endmodule

// File: rtl/hmap_top.sv
module hmap_top #(
  parameter int BUS_W      = 16,
  parameter int ADDR_W     = 14,
  parameter int LO_W       = 8,
  parameter int PROT_WORDS = 32,
  parameter int PM_AW      = 10,
  parameter int DM_AW      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_mode,
  input  logic             host_sel,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             host_ale,
  input  logic [BUS_W-1:0] host_ad_in,
  output logic [BUS_W-1:0] host_ad_out,
  output logic             host_ad_oe,
  output logic             host_ack,
  output logic             boot_hold
);
  localparam int PM_W = BUS_W + LO_W;

  logic [3:0] strobes_s;
  logic pm_we, pm_re, dm_we, dm_re, rd_dm, rd_lo;
  logic [PM_AW-1:0] pm_addr;
  logic [DM_AW-1:0] dm_addr;
  logic [PM_W-1:0]  pm_wdata, pm_q;
  logic [BUS_W-1:0] dm_wdata, dm_q;

  hmap_sync #(.W(4), .STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({host_ale, host_sel, host_rd, host_wr}),
    .q   (strobes_s)
  );

  hmap_ctrl #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W), .LO_W(LO_W), .PROT_WORDS(PROT_WORDS),
    .PM_AW(PM_AW), .DM_AW(DM_AW)
  ) i_ctrl (
    .clk       (clk),
    .rst       (rst),
    .boot_mode (boot_mode),
    .ale_s     (strobes_s[3]),
    .sel_s     (strobes_s[2]),
    .rd_s      (strobes_s[1]),
    .wr_s      (strobes_s[0]),
    .ad_in     (host_ad_in),
    .ack       (host_ack),
    .oe        (host_ad_oe),
    .boot_hold (boot_hold),
    .pm_we     (pm_we),
    .pm_re     (pm_re),
    .pm_addr   (pm_addr),
    .pm_wdata  (pm_wdata),
    .dm_we     (dm_we),
    .dm_re     (dm_re),
    .dm_addr   (dm_addr),
    .dm_wdata  (dm_wdata),
    .rd_dm     (rd_dm),
    .rd_lo     (rd_lo)
  );

  hmap_ram #(.W(PM_W), .AW(PM_AW)) i_pm_ram (
    .clk (clk), .we (pm_we), .re (pm_re), .addr (pm_addr),
    .wdata (pm_wdata), .q (pm_q)
  );

  hmap_ram #(.W(BUS_W), .AW(DM_AW)) i_dm_ram (
    .clk (clk), .we (dm_we), .re (dm_re), .addr (dm_addr),
    .wdata (dm_wdata), .q (dm_q)
  );

  always_comb begin
    if (rd_dm)      host_ad_out = dm_q;
    else if (rd_lo) host_ad_out = {{(BUS_W-LO_W){1'b0}}, pm_q[LO_W-1:0]};
    else            host_ad_out = pm_q[PM_W-1:LO_W];
  end
endmodule

// File: tb/test_hmap_top.sv
module test_hmap_top;
  localparam int AW = 10;

  logic clk = 1'b0, rst = 1'b1, boot_mode = 1'b1;
  logic sel = 1'b0, rd = 1'b0, wr = 1'b0, ale = 1'b0;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic oe, ack, bh;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [23:0] pm_m [1 << AW];
  bit          pm_v [1 << AW];
  logic [15:0] dm_m [1 << AW];
  bit          dm_v [1 << AW];
  logic [13:0] cur_addr = '0;
  bit          cur_dm = 1'b0, cur_beat = 1'b0;
  logic [15:0] pm_hold = '0;

  always #10 clk = ~clk;

  hmap_top #(.PM_AW(AW), .DM_AW(AW)) i_hmap_top (
    .clk(clk), .rst(rst), .boot_mode(boot_mode),
    .host_sel(sel), .host_rd(rd), .host_wr(wr), .host_ale(ale),
    .host_ad_in(ad_in), .host_ad_out(ad_out), .host_ad_oe(oe),
    .host_ack(ack), .boot_hold(bh)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_prot(input logic [13:0] a);
    return a >= 14'h3FE0;
  endfunction

  task automatic do_latch(input bit dm, input logic [13:0] a);
    @(negedge clk);
    ad_in = {1'b0, dm, a};
    ale = 1'b1;
    repeat (3) @(negedge clk);
    ale = 1'b0;
    repeat (5) @(negedge clk);
    cur_addr = a; cur_dm = dm; cur_beat = 1'b0;
  endtask

  // one handshake with R3 timing checks; returns the bus value after edge 4
  task automatic do_access(input bit w, input logic [15:0] wd, output logic [15:0] rdv,
                           input int hold_extra);
    @(negedge clk);
    if (w) ad_in = wd;
    sel = 1'b1; rd = !w; wr = w;
    repeat (3) @(negedge clk);
    chk(ack, 0, "R3 ack low after edge 3");
    @(negedge clk);
    chk(ack, 1, "R3 ack high after edge 4");
    chk(oe, !w, "R3 drive enable on read");
    rdv = ad_out;
    repeat (hold_extra) @(negedge clk);
    sel = 1'b0; rd = 1'b0; wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(oe, 0, "R3 drive enable released");
  endtask

  task automatic host_write(input logic [15:0] d, input int hold_extra);
    logic [15:0] dummy;
    do_access(1'b1, d, dummy, hold_extra);
    if (cur_dm) begin
      if (!is_prot(cur_addr)) begin
        dm_m[cur_addr[AW-1:0]] = d; dm_v[cur_addr[AW-1:0]] = 1'b1;
      end
      cur_addr = cur_addr + 1'b1;
    end else if (!cur_beat) begin
      pm_hold = d; cur_beat = 1'b1;
    end else begin
      pm_m[cur_addr[AW-1:0]] = {pm_hold, d[7:0]}; pm_v[cur_addr[AW-1:0]] = 1'b1;
      cur_beat = 1'b0; cur_addr = cur_addr + 1'b1;
    end
  endtask

  task automatic host_read(input string tag);
    logic [15:0] got, exp;
    bit valid;
    do_access(1'b0, 16'h0, got, 0);
    if (cur_dm) begin
      valid = dm_v[cur_addr[AW-1:0]]; exp = dm_m[cur_addr[AW-1:0]];
      cur_addr = cur_addr + 1'b1;
    end else begin
      valid = pm_v[cur_addr[AW-1:0]];
      exp = cur_beat ? {8'h00, pm_m[cur_addr[AW-1:0]][7:0]} : pm_m[cur_addr[AW-1:0]][23:8];
      if (cur_beat) cur_addr = cur_addr + 1'b1;
      cur_beat = !cur_beat;
    end
    if (valid) chk(got, exp, tag);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) begin pm_v[i] = 0; dm_v[i] = 0; end
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(ack, 1, "R1 ack after reset");
    chk(oe, 0, "R1 drive enable after reset");
    chk(bh, 1, "R1 boot hold after reset");

    // R7 and R6: boot word at program address 0
    do_latch(1'b0, 14'h0000);
    host_write(16'hBEEF, 0);
    chk(bh, 1, "R7 boot hold after first beat");
    host_write(16'hFF5A, 0);
    chk(bh, 0, "R7 boot hold cleared by second beat");
    host_write(16'h1234, 0);
    host_write(16'h0056, 0);
    do_latch(1'b0, 14'h0000);
    host_read("R6 program upper half");
    host_read("R6 program low byte, upper byte zero");
    host_read("R6 next word upper half, address stepped once");
    host_read("R6 next word low byte");

    // R2: relatch mid-word returns to the upper-half beat
    do_latch(1'b0, 14'h0000);
    host_read("R2 first beat before relatch");
    do_latch(1'b0, 14'h0001);
    host_read("R2 relatch restarts at upper half");

    // R5: protected alias of 0x03E0
    do_latch(1'b1, 14'h03E0);
    host_write(16'hA5A5, 0);
    do_latch(1'b1, 14'h3FE0);
    host_write(16'h5A5A, 0);
    host_write(16'h7777, 0);
    do_latch(1'b1, 14'h03E0);
    host_read("R5 protected write discarded");
    host_read("R5 address stepped past protected word");

    // R4: wrap from 0x3FFF to 0x0000
    do_latch(1'b1, 14'h03FF);
    host_write(16'h1111, 0);
    host_write(16'h2222, 0);
    do_latch(1'b1, 14'h3FFF);
    host_read("R4 read at top address");
    host_read("R4 address wrapped to zero");

    // R8: long strobe performs one access
    do_latch(1'b1, 14'h0100);
    host_write(16'hC001, 12);
    host_write(16'hC002, 0);
    do_latch(1'b1, 14'h0100);
    host_read("R8 held strobe first word");
    host_read("R8 held strobe advanced only once");

    // R9: read without select
    do_latch(1'b1, 14'h0100);
    @(negedge clk);
    rd = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk(ack, 1, "R9 no access without select");
    end
    rd = 1'b0;
    repeat (4) @(negedge clk);
    host_read("R9 address unchanged after unselected strobe");

    // random bursts
    for (int it = 0; it < 30; it++) begin
      bit dm;
      logic [13:0] a;
      int n;
      dm = 1'($urandom % 2);
      a  = ($urandom % 4 == 0) ? 14'(14'h3FD8 + ($urandom % 40)) : 14'($urandom);
      if (!dm && a == 14'h0) a = 14'h0010;
      n  = 1 + ($urandom % 4);
      do_latch(dm, a);
      for (int j = 0; j < (dm ? n : 2 * n); j++) host_write(16'($urandom), 0);
      do_latch(dm, a);
      for (int j = 0; j < (dm ? n : 2 * n); j++)
        host_read(dm ? "R4 random data read-back" : "R6 random program read-back");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule